// File: doc/BRIEF.md
# SPI Port with Per-Word Request Handshake

This block is a serial peripheral port that can run either as the bus master or as a slave. A control input picks the role. Each word crosses the bus in clock mode 0: SCK idles low, both sides sample on the rising edge and change data on the falling edge, and bits go most significant first. Every word is paced by an active-low request line, and the direction of that line follows the role. As a slave, the block drives the line low once it holds a word ready to send. It releases the line on the first rising SCK of that word. As a master, the block watches the line from the external slave. It starts one word for each high-to-low transition that it sees.

Locally, a one-word transmit holding register is filled through a valid/ready handshake. Each received word comes out with a single-cycle valid pulse. In master mode the block makes SCK from the system clock with a programmable divider. In slave mode the SCK, select and MOSI inputs pass through two-flop synchronisers before use, as does the request input. Driving the select line low while the block is master sets a sticky bus-error flag. Pads are modelled as separate data-out, output-enable and data-in ports, so every line that is tri-stated shows up as an enable at 0.

Top module: `spi_req_port`

## Requirements
- R1: In master mode with cfg_en=1, each SCK half period lasts cfg_div+1 system clocks. The word in the holding register goes out on mosi_o MSB first. The MISO bits sampled on the rising edges are returned on rx_data.
- R2: In master mode with cfg_req_en=1, a word starts only after req_in_n goes from high to low while a transmit word is held. Each such transition starts at most one word, so a request line that stays low after a word does not start another.
- R3: In master mode with cfg_req_en=0, a held transmit word starts at once, without waiting for the request line.
- R4: In slave mode, while ss_in_n is low, the block shifts in mosi_in on each synchronised rising SCK. It drives miso_o with its transmit word, MSB first, and changes the bit after each falling SCK.
- R5: In slave mode, while ss_in_n is high, SCK edges are ignored (no bit is counted and no word completes) and miso_oe is 0.
- R6: In slave mode with cfg_req_en=1, req_o_n is driven low once a transmit word is loaded and the port sits between words. It goes high after the first rising SCK of that word.
- R7: req_oe is 0 during reset, whenever cfg_req_en is 0, and in master mode.
- R8: In master mode with cfg_en=1, a low level on ss_in_n sets bus_err. bus_err stays 1 until an err_clr pulse arrives with ss_in_n high.
- R9: tx_ready is 1 exactly when cfg_en=1 and the holding register is empty. A word is taken when tx_valid and tx_ready are both 1 on a clock edge.
- R10: In master mode, mosi_o is stable during every cycle in which SCK stays high.
- R11: Each completed word raises rx_valid for exactly one cycle, with the word on rx_data in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Port enable |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_req_en | input | 1 | Enables the request handshake |
| cfg_div | input | DIV_W | SCK half period minus one, in system clocks |
| err_clr | input | 1 | Write-one-to-clear strobe for bus_err |
| tx_data | input | WORD_W | Word to transmit |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Holding register is empty |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle pulse: rx_data holds a new word |
| bus_err | output | 1 | Sticky bus-error flag |
| sck_o | output | 1 | SCK driven in master mode |
| sck_oe | output | 1 | SCK output enable |
| sck_in | input | 1 | SCK from the pad, used in slave mode |
| ss_in_n | input | 1 | Active-low slave select from the pad |
| mosi_o | output | 1 | Serial data out in master mode |
| mosi_oe | output | 1 | MOSI output enable |
| mosi_in | input | 1 | Serial data in, slave mode |
| miso_o | output | 1 | Serial data out in slave mode |
| miso_oe | output | 1 | MISO output enable |
| miso_in | input | 1 | Serial data in, master mode |
| req_o_n | output | 1 | Active-low ready request, slave mode |
| req_oe | output | 1 | Request line output enable |
| req_in_n | input | 1 | Active-low request from an external slave |

## Verification
Both roles transfer random words at random divider settings. Because the bench compares both serial directions bit for bit, a swapped bit order, a sample taken on the wrong edge or an off-by-one in the bit count shows up as a corrupted word. Measuring the first SCK high phase separates a correct divider from one that is one count short or one count long. Directed cases hold the request line low across two words, leave it high, and disable the handshake, which shows level-triggered starting apart from edge-triggered starting. Further cases toggle SCK with select deasserted, and drive select low while the block is master, which tells ignored edges apart from counted ones and a sticky error flag apart from a transient one.

// File: rtl/spi_req_pkg.sv
// Shared types for the request-paced SPI port.
// Assumes nothing beyond a single system clock domain.
package spi_req_pkg;
    typedef enum logic [0:0] {M_IDLE = 1'b0, M_RUN = 1'b1} mst_state_t;
endpackage

// File: rtl/spi_req_sync.sv
// Two-flop synchroniser bank. Each bit has its own reset value so that
// active-low lines come out of reset as deasserted.
// Assumes the inputs are level signals slower than two system clocks.
module spi_req_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            logic s1, s2;
            // two-stage capture of one asynchronous bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1 <= RST_VAL[i];
                    s2 <= RST_VAL[i];
                end else begin
                    s1 <= d[i];
                    s2 <= s1;
                end
            end
            assign q[i] = s2;
        end
    endgenerate
endmodule

// File: rtl/spi_req_div.sv
// Clock divider for master SCK. While run is high, tick fires once every
// div+1 system clocks, and each tick marks one SCK half period.
// Assumes div is held steady during a word.
module spi_req_div #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // count system clocks within the current half period
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_req_shift.sv
// Shared shift datapath. The transmit side loads a word and shifts it
// left on shift_out. The receive side shifts in_bit in on sample.
// Assumes load and shift_out are never high together.
module spi_req_shift #(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic              shift_out,
    input  logic              sample,
    input  logic              in_bit,
    output logic              tx_msb,
    output logic [WORD_W-1:0] rx_word
);
    logic [WORD_W-1:0] tx_sr;

    // transmit register: load a word or move to the next bit
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_sr <= '0;
        else if (load)      tx_sr <= load_val;
        else if (shift_out) tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
    end

    // receive register: collect one bit per sampling edge
    always_ff @(posedge clk) begin
        if (!rst_n)      rx_word <= '0;
        else if (sample) rx_word <= {rx_word[WORD_W-2:0], in_bit};
    end

    assign tx_msb = tx_sr[WORD_W-1];
endmodule

// File: rtl/spi_req_port.sv
// Dual-role SPI port, clock mode 0, MSB first, one word per request.
// Master: generates SCK and starts one word per falling edge of the
// synchronised request input (or at once when the handshake is off).
// Slave: works on synchronised SCK/select/MOSI and drives the request low
// while a word is loaded and waiting.
// Assumes slave-mode SCK half periods of at least four system clocks.
module spi_req_port
    import spi_req_pkg::*;
#(
    parameter int unsigned WORD_W = 8,
    parameter int unsigned DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_master,
    input  logic              cfg_req_en,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              err_clr,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              bus_err,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_in,
    input  logic              ss_in_n,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              mosi_in,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              miso_in,
    output logic              req_o_n,
    output logic              req_oe,
    input  logic              req_in_n
);
    localparam int unsigned CNT_W = $clog2(WORD_W + 1);

    // synchronised pad inputs: {select, sck, mosi, request}
    logic ss_s, sck_s, mosi_s, req_s;
    spi_req_sync #(.W(4), .RST_VAL(4'b1001)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ss_in_n, sck_in, mosi_in, req_in_n}),
        .q({ss_s, sck_s, mosi_s, req_s})
    );

    logic              sck_d, req_d;
    logic              tx_full;
    logic [WORD_W-1:0] tx_buf;
    mst_state_t        st;
    logic [CNT_W-1:0]  mbits, sbits;
    logic              sck_r, req_pend, s_rdy;
    logic              tick, tx_msb;
    logic [WORD_W-1:0] rx_word;

    // master control terms
    logic run, m_start, m_rise, m_fall, m_done, go_ok, req_fall;
    assign run      = (st == M_RUN);
    assign req_fall = req_d && !req_s;
    assign go_ok    = cfg_req_en ? req_pend : 1'b1;
    assign m_start  = cfg_en && cfg_master && !run && tx_full && go_ok;
    assign m_rise   = tick && !sck_r;
    assign m_fall   = tick && sck_r;
    assign m_done   = m_fall && (mbits == CNT_W'(WORD_W));

    // slave control terms
    logic s_act, s_rise, s_fall, s_done, s_load;
    assign s_act  = cfg_en && !cfg_master && !ss_s;
    assign s_rise = s_act && sck_s && !sck_d;
    assign s_fall = s_act && !sck_s && sck_d;
    assign s_done = s_rise && (sbits == CNT_W'(WORD_W - 1));
    assign s_load = cfg_en && !cfg_master && !s_rdy && (sbits == '0)
                    && tx_full && !s_rise;

    spi_req_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .div(cfg_div), .tick(tick)
    );

    spi_req_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .load(m_start || s_load),
        .load_val(tx_buf),
        .shift_out((m_fall && !m_done) || (s_fall && sbits != '0)),
        .sample(m_rise || s_rise),
        .in_bit(cfg_master ? miso_in : mosi_s),
        .tx_msb(tx_msb),
        .rx_word(rx_word)
    );

    // edge-detect history for the synchronised SCK and request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            req_d <= 1'b1;
        end else begin
            sck_d <= sck_s;
            req_d <= req_s;
        end
    end

    // transmit holding register fed by the valid/ready handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_full <= 1'b0;
            tx_buf  <= '0;
        end else if (tx_valid && tx_ready) begin
            tx_full <= 1'b1;
            tx_buf  <= tx_data;
        end else if (m_start || s_load) begin
            tx_full <= 1'b0;
        end
    end
    assign tx_ready = cfg_en && !tx_full;

    // latch one pending request per falling edge of the request input
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_en || !cfg_master) req_pend <= 1'b0;
        else if (m_start)                    req_pend <= 1'b0;
        else if (req_fall)                   req_pend <= 1'b1;
    end

    // master sequencer: SCK generation and bit counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= M_IDLE;
            sck_r <= 1'b0;
            mbits <= '0;
        end else if (m_start) begin
            st    <= M_RUN;
            sck_r <= 1'b0;
            mbits <= '0;
        end else if (run && tick) begin
            sck_r <= !sck_r;
            if (m_rise) mbits <= mbits + 1'b1;
            if (m_done) st <= M_IDLE;
        end
    end

    // slave bit counter and request-ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sbits <= '0;
            s_rdy <= 1'b0;
        end else begin
            if (!s_act)      sbits <= '0;
            else if (s_done) sbits <= '0;
            else if (s_rise) sbits <= sbits + 1'b1;
            if (cfg_master || !cfg_en) s_rdy <= 1'b0;
            else if (s_rise)           s_rdy <= 1'b0;
            else if (s_load)           s_rdy <= 1'b1;
        end
    end

    // received word and its one-cycle valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= m_done || s_done;
            if (m_done) rx_data <= rx_word;
            else if (s_done) rx_data <= {rx_word[WORD_W-2:0], mosi_s};
        end
    end

    // sticky bus error: select driven while master
    always_ff @(posedge clk) begin
        if (!rst_n)                            bus_err <= 1'b0;
        else if (cfg_en && cfg_master && !ss_s) bus_err <= 1'b1;
        else if (err_clr)                      bus_err <= 1'b0;
    end

    assign sck_o   = sck_r;
    assign sck_oe  = cfg_en && cfg_master;
    assign mosi_o  = tx_msb;
    assign mosi_oe = cfg_en && cfg_master;
    assign miso_o  = tx_msb;
    assign miso_oe = s_act;
    assign req_o_n = !s_rdy;
    assign req_oe  = rst_n && cfg_en && cfg_req_en && !cfg_master;
endmodule

// File: rtl/spi_req_port_chk.sv
// Property checker for spi_req_port, attached with bind.
module spi_req_port_chk #(
    parameter int unsigned WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_en,
    input logic              cfg_master,
    input logic              cfg_req_en,
    input logic              err_clr,
    input logic              rx_valid,
    input logic              bus_err,
    input logic              sck_o,
    input logic              mosi_o,
    input logic              mosi_oe,
    input logic              miso_oe,
    input logic              req_oe,
    input logic              tx_valid,
    input logic              tx_ready
);
    AST_RXV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R11
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err && !err_clr |=> bus_err); // R8
    AST_REQ_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_req_en || cfg_master) |-> !req_oe); // R7
    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_master && sck_o && $past(sck_o) && $past(cfg_master) |-> $stable(mosi_o)); // R10
    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !(mosi_oe && miso_oe)); // R5
    AST_TX_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> !tx_ready); // R9
endmodule

bind spi_req_port spi_req_port_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_master(cfg_master),
    .cfg_req_en(cfg_req_en), .err_clr(err_clr), .rx_valid(rx_valid),
    .bus_err(bus_err), .sck_o(sck_o), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_oe(miso_oe), .req_oe(req_oe), .tx_valid(tx_valid), .tx_ready(tx_ready)
);

// File: tb/spi_req_port_tb.sv
module spi_req_port_tb_top;
    localparam int W = 8;
    localparam int DW = 4;
    localparam int H = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_en = 0, cfg_master = 0, cfg_req_en = 0, err_clr = 0;
    logic [DW-1:0] cfg_div = '0;
    logic [W-1:0] tx_data = '0;
    logic tx_valid = 0, sck_in = 0, ss_in_n = 1, mosi_in = 0, miso_in = 0, req_in_n = 1;
    logic tx_ready, rx_valid, bus_err, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic req_o_n, req_oe;
    logic [W-1:0] rx_data;

    int tests = 0, fails = 0, rx_cnt = 0;
    logic [W-1:0] rx_last = '0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_req_port #(.WORD_W(W), .DIV_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_master(cfg_master),
        .cfg_req_en(cfg_req_en), .cfg_div(cfg_div), .err_clr(err_clr),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .bus_err(bus_err),
        .sck_o(sck_o), .sck_oe(sck_oe), .sck_in(sck_in), .ss_in_n(ss_in_n),
        .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_in(mosi_in),
        .miso_o(miso_o), .miso_oe(miso_oe), .miso_in(miso_in),
        .req_o_n(req_o_n), .req_oe(req_oe), .req_in_n(req_in_n)
    );

    // count received words away from the active edge
    always @(negedge clk) if (rst_n && rx_valid) begin
        rx_cnt++;
        rx_last = rx_data;
    end

    function automatic int exp_half(input int div);
        return div + 1;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [W-1:0] w);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data = w; tx_valid = 1;
        @(negedge clk);
        tx_valid = 0;
    endtask

    // bench acts as external slave while the DUT is master
    task automatic m_word(input logic [W-1:0] tw, input logic [W-1:0] sw,
                          input int div, input bit use_req);
        logic [W-1:0] got = '0;
        int nr = 0, nf = 0, cyc = 0, tr = 0, hp = 0, guard = 0, c0;
        bit prev, seen = 0;
        cfg_div = DW'(div);
        miso_in = sw[W-1];
        c0 = rx_cnt;
        push(tw);
        if (use_req) req_in_n = 0;
        prev = sck_o;
        while (!seen && guard < 3000) begin
            @(negedge clk);
            guard++; cyc++;
            if (sck_o && !prev) begin
                got = {got[W-2:0], mosi_o}; nr++;
                if (nr == 1) tr = cyc;
            end
            if (!sck_o && prev) begin
                nf++;
                if (nf == 1) hp = cyc - tr;
                if (nf < W) miso_in = sw[W-1-nf];
            end
            prev = sck_o;
            if (rx_valid) seen = 1;
        end
        chk(got == tw, "R1 mosi word", got, tw);
        chk(seen && rx_data == sw, "R1 rx_data", rx_data, sw);
        chk(hp == exp_half(div), "R1 half period", hp, exp_half(div));
        repeat (2) @(negedge clk);
        chk(rx_cnt == c0 + 1, "R11 one pulse", rx_cnt - c0, 1);
        req_in_n = 1;
        repeat (6) @(negedge clk);
    endtask

    // bench acts as external master while the DUT is slave
    task automatic s_word(input logic [W-1:0] tw, input logic [W-1:0] mw);
        logic [W-1:0] got = '0;
        int c0 = rx_cnt;
        push(tw);
        repeat (6) @(negedge clk);
        chk(req_o_n == 0 && req_oe == 1, "R6 request asserted", req_o_n, 0);
        ss_in_n = 0;
        repeat (4) @(negedge clk);
        chk(miso_oe == 1, "R4 miso driven", miso_oe, 1);
        for (int i = 0; i < W; i++) begin
            mosi_in = mw[W-1-i];
            repeat (H) @(negedge clk);
            got = {got[W-2:0], miso_o};
            sck_in = 1;
            repeat (H) @(negedge clk);
            if (i == 0) chk(req_o_n == 1, "R6 request released", req_o_n, 1);
            sck_in = 0;
        end
        repeat (H) @(negedge clk);
        ss_in_n = 1;
        repeat (6) @(negedge clk);
        chk(got == tw, "R4 miso word", got, tw);
        chk(rx_cnt == c0 + 1 && rx_last == mw, "R4 rx word", rx_last, mw);
    endtask

    initial begin : main
        int seed, c0;
        logic [W-1:0] a, b;
        seed = $urandom(32'd1357);
        repeat (4) @(negedge clk);
        chk(req_oe == 0, "R7 reset hiz", req_oe, 0);
        chk(rx_valid == 0 && bus_err == 0 && sck_o == 0, "R11 reset outputs",
            {rx_valid, bus_err, sck_o}, 0);
        rst_n = 1;
        cfg_en = 1; cfg_master = 1; cfg_req_en = 1;
        @(negedge clk);
        chk(tx_ready == 1 && req_oe == 0, "R7 master hiz", req_oe, 0);

        // R2: held word without request does not start
        push(8'hA5);
        repeat (40) @(negedge clk);
        chk(sck_o == 0 && tx_ready == 0, "R2 no start without request", sck_o, 0);
        chk(tx_ready == 0, "R9 ready low when full", tx_ready, 0);
        req_in_n = 0;
        repeat (60) @(negedge clk);
        chk(rx_cnt == 1, "R2 start on request", rx_cnt, 1);
        // R2: request left low; a new word must wait
        push(8'h3C);
        repeat (80) @(negedge clk);
        chk(rx_cnt == 1, "R2 level does not restart", rx_cnt, 1);
        req_in_n = 1;
        repeat (6) @(negedge clk);
        req_in_n = 0;
        repeat (80) @(negedge clk);
        chk(rx_cnt == 2, "R2 next edge restarts", rx_cnt, 2);
        req_in_n = 1;
        repeat (6) @(negedge clk);

        // random master words, corner words included
        m_word(8'h80, 8'h01, 0, 1);
        m_word(8'hFF, 8'h00, 3, 1);
        for (int k = 0; k < 6; k++) begin
            a = W'($urandom); b = W'($urandom);
            m_word(a, b, int'($urandom % 4), 1);
        end
        // R3: handshake disabled
        cfg_req_en = 0;
        m_word(8'h5A, 8'hC3, 1, 0);
        chk(req_oe == 0, "R7 req disabled hiz", req_oe, 0);

        // R8 bus error
        ss_in_n = 0;
        repeat (5) @(negedge clk);
        ss_in_n = 1;
        repeat (5) @(negedge clk);
        chk(bus_err == 1, "R8 error sticky", bus_err, 1);
        err_clr = 1; @(negedge clk); err_clr = 0; @(negedge clk);
        chk(bus_err == 0, "R8 error cleared", bus_err, 0);

        // slave role
        cfg_master = 0; cfg_req_en = 1;
        repeat (4) @(negedge clk);
        chk(miso_oe == 0, "R5 miso hiz when unselected", miso_oe, 0);
        s_word(8'h81, 8'h7E);
        for (int k = 0; k < 5; k++) begin
            a = W'($urandom); b = W'($urandom);
            s_word(a, b);
        end
        // R5: edges with select high are ignored
        c0 = rx_cnt;
        for (int i = 0; i < W; i++) begin
            sck_in = 1; repeat (H) @(negedge clk);
            sck_in = 0; repeat (H) @(negedge clk);
        end
        chk(rx_cnt == c0 && miso_oe == 0, "R5 edges ignored", rx_cnt - c0, 0);
        s_word(8'h0F, 8'hF0);
        cfg_req_en = 0;
        @(negedge clk);
        chk(req_oe == 0, "R7 slave req disabled", req_oe, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule